// File: doc/BRIEF.md
# Low-Power Mode Control Register

This block is the power-control special-function register of a small 8-bit microcontroller, together with the clock gating it drives. Software writes one register address. That register holds a serial baud-doubling bit, two free flags, and an enable/start pair for each of two low-power modes: idle and power-down. Three clock-enable outputs come from a three-state mode machine (run, idle, power-down). One gates the CPU core, one gates the peripheral group and one gates the watchdog.

Entering a mode takes two writes. The first sets the mode's enable bit. The very next write must set the matching start bit. Any other write in between disarms the enable. Idle stops the CPU and watchdog clocks and keeps the peripherals running. Only clocks are gated, so all CPU state survives idle. A wake-up interrupt request returns the block to run. Power-down stops every clock. Only reset leaves power-down, and reset also returns the register to its reset value. If both modes are started by the same write, power-down wins.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, the register reads 0x00, all three clock enables are 1, and neither mode output is set.
- R2: A write with address 0x87 loads the baud-double bit (bit 7), flag 1 (bit 3) and flag 0 (bit 2) from the data. A write to any other address changes nothing. Bit 4 is reserved and always reads 0.
- R3: `baudDouble` is 1 exactly when bit 7 is set and `serMode` is 1, 2 or 3. It is 0 for serial mode 0.
- R4: If an enable bit is clear, a write loads it from the data: idle enable is bit 0 and power-down enable is bit 1.
- R5: A write that sets a start bit (idle start is bit 5, power-down start is bit 6) while the matching enable is clear is ignored. The start bit reads 0 and no mode is entered.
- R6: Once an enable bit is set, the next write to the register clears it, whatever that write's data holds. A start bit set by that write is accepted only if its enable was set before the write.
- R7: An accepted idle start reads back as 1 for one cycle. On the following clock edge, the block enters idle. In idle, `cpuClkEn` and `wdtClkEn` are 0, `periClkEn` is 1, `modeIdle` is 1 and the start bit reads 0.
- R8: While in idle, `wakeIrq` returns the block to run on the next clock edge. All clocks are re-enabled, and the flags and baud bit keep their values.
- R9: Power-down sets all three clock enables to 0. `wakeIrq` does not leave it. Reset leaves it and restores the reset value.
- R10: If one write sets both start bits with both enables armed, the block enters power-down, not idle.
- R11: Register writes are ignored while the block is in idle or power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sfrAddr | input | 8 | Special-function register address of the current write |
| sfrWrEn | input | 1 | Write strobe |
| sfrWrData | input | 8 | Write data |
| serMode | input | 2 | Current serial-port mode (0 to 3) |
| wakeIrq | input | 1 | Enabled interrupt request, used to wake from idle |
| regRdData | output | 8 | Current register contents |
| baudDouble | output | 1 | Baud-rate doubling request to the serial port |
| cpuClkEn | output | 1 | CPU core clock enable |
| periClkEn | output | 1 | Peripheral group clock enable |
| wdtClkEn | output | 1 | Watchdog clock enable |
| modeIdle | output | 1 | Block is in idle |
| modePdown | output | 1 | Block is in power-down |

## Verification
The register path is driven with a table of writes to the block's own address and to neighbouring addresses, each paired with a different serial mode. This separates a correct address decode from one that responds to nearby addresses, and shows the baud-double output depending on both the bit and the serial mode. Mode entry is tried with four sequences: a start with no enable, an enable followed by an unrelated write, a proper enable-then-start pair, and both modes armed and started together. These show whether the block gates on the enable, whether a stray write disarms it, and whether power-down takes priority. Wake-up is driven in idle and again in power-down, which confirms that only idle responds to it.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  localparam int REG_W = 8;
  localparam int BIT_SMOD = 7;
  localparam int BIT_PDS  = 6;
  localparam int BIT_IDS  = 5;
  localparam int BIT_GF1  = 3;
  localparam int BIT_GF0  = 2;
  localparam int BIT_PDE  = 1;
  localparam int BIT_IDE  = 0;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_IDLE  = 2'd1,
    ST_PDOWN = 2'd2
  } pmState_t;

  typedef struct packed {
    logic wrStb;
    logic clrStarts;
  } pmStrobe_t;
endpackage

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  pmStrobe_t         strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        serMode,
  output logic [DATA_W-1:0] rdData,
  output logic              idleReq,
  output logic              pdReq,
  output logic              baudDouble
);
  logic smodQ, pdsQ, idsQ, gf1Q, gf0Q, pdeQ, ideQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      smodQ <= 1'b0;
      pdsQ  <= 1'b0;
      idsQ  <= 1'b0;
      gf1Q  <= 1'b0;
      gf0Q  <= 1'b0;
      pdeQ  <= 1'b0;
      ideQ  <= 1'b0;
    end else begin
      if (strobe.wrStb) begin
        smodQ <= wrData[BIT_SMOD];
        gf1Q  <= wrData[BIT_GF1];
        gf0Q  <= wrData[BIT_GF0];
        // an armed enable is consumed by the very next write
        ideQ  <= ideQ ? 1'b0 : wrData[BIT_IDE];
        pdeQ  <= pdeQ ? 1'b0 : wrData[BIT_PDE];
      end
      if (strobe.clrStarts) begin
        idsQ <= 1'b0;
        pdsQ <= 1'b0;
      end else if (strobe.wrStb) begin
        idsQ <= idsQ | (ideQ & wrData[BIT_IDS]);
        pdsQ <= pdsQ | (pdeQ & wrData[BIT_PDS]);
      end
    end
  end

  always_comb begin
    rdData           = '0;
    rdData[BIT_SMOD] = smodQ;
    rdData[BIT_PDS]  = pdsQ;
    rdData[BIT_IDS]  = idsQ;
    rdData[BIT_GF1]  = gf1Q;
    rdData[BIT_GF0]  = gf0Q;
    rdData[BIT_PDE]  = pdeQ;
    rdData[BIT_IDE]  = ideQ;
  end

  assign idleReq    = idsQ;
  assign pdReq      = pdsQ;
  assign baudDouble = smodQ & (serMode != 2'd0);
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter logic [7:0]  REG_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              idleReq,
  input  logic              pdReq,
  input  logic              wakeIrq,
  output pmStrobe_t         strobe,
  output logic              cpuClkEn,
  output logic              periClkEn,
  output logic              wdtClkEn,
  output logic              inIdle,
  output logic              inPdown
);
  localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(REG_ADDR);

  pmState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_RUN: begin
        if (pdReq)        stateD = ST_PDOWN;
        else if (idleReq) stateD = ST_IDLE;
      end
      ST_IDLE:  if (wakeIrq) stateD = ST_RUN;
      ST_PDOWN: stateD = ST_PDOWN;
      default:  stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe.wrStb     = wrEn && (addr == MY_ADDR) && (stateQ == ST_RUN);
    strobe.clrStarts = (stateQ == ST_RUN) && (stateD != ST_RUN);
  end

  assign cpuClkEn  = (stateQ == ST_RUN);
  assign wdtClkEn  = (stateQ == ST_RUN);
  assign periClkEn = (stateQ != ST_PDOWN);
  assign inIdle    = (stateQ == ST_IDLE);
  assign inPdown   = (stateQ == ST_PDOWN);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int         ADDR_W   = 8,
  parameter logic [7:0] REG_ADDR = 8'h87
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic              sfrWrEn,
  input  logic [REG_W-1:0]  sfrWrData,
  input  logic [1:0]        serMode,
  input  logic              wakeIrq,
  output logic [REG_W-1:0]  regRdData,
  output logic              baudDouble,
  output logic              cpuClkEn,
  output logic              periClkEn,
  output logic              wdtClkEn,
  output logic              modeIdle,
  output logic              modePdown
);
  pmStrobe_t strobe;
  logic idleReq, pdReq;

  pwr_mode_fsm #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_fsm (
    .clk(clk), .rstN(rstN), .addr(sfrAddr), .wrEn(sfrWrEn),
    .idleReq(idleReq), .pdReq(pdReq), .wakeIrq(wakeIrq),
    .strobe(strobe), .cpuClkEn(cpuClkEn), .periClkEn(periClkEn),
    .wdtClkEn(wdtClkEn), .inIdle(modeIdle), .inPdown(modePdown)
  );

  pwr_mode_regs #(.DATA_W(REG_W)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(sfrWrData),
    .serMode(serMode), .rdData(regRdData), .idleReq(idleReq),
    .pdReq(pdReq), .baudDouble(baudDouble)
  );
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wakeIrq,
  input logic [7:0] regRdData,
  input logic       cpuClkEn,
  input logic       periClkEn,
  input logic       wdtClkEn,
  input logic       modeIdle,
  input logic       modePdown
);
  p_idle_after_start_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeIdle) |-> ($past(regRdData[5]) && !$past(regRdData[6])));

  p_idle_gating_r7: assert property (@(posedge clk) disable iff (!rstN)
    modeIdle |-> (periClkEn && !cpuClkEn && !wdtClkEn && regRdData[6:5] == 2'b00));

  p_wake_r8: assert property (@(posedge clk) disable iff (!rstN)
    (modeIdle && wakeIrq) |=> (!modeIdle && cpuClkEn && wdtClkEn));

  p_pdown_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    modePdown |=> (modePdown && !cpuClkEn && !periClkEn && !wdtClkEn));

  p_one_mode_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({modeIdle, modePdown}));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[4] == 1'b0);
endmodule

bind pwr_mode_ctrl pwr_mode_chk u_chk (
  .clk(clk), .rstN(rstN), .wakeIrq(wakeIrq), .regRdData(regRdData),
  .cpuClkEn(cpuClkEn), .periClkEn(periClkEn), .wdtClkEn(wdtClkEn),
  .modeIdle(modeIdle), .modePdown(modePdown)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] sfrAddr = '0;
  logic       sfrWrEn = 1'b0;
  logic [7:0] sfrWrData = '0;
  logic [1:0] serMode = '0;
  logic       wakeIrq = 1'b0;
  logic [7:0] regRdData;
  logic baudDouble, cpuClkEn, periClkEn, wdtClkEn, modeIdle, modePdown;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwr_mode_ctrl u0 (
    .clk(clk), .rstN(rstN), .sfrAddr(sfrAddr), .sfrWrEn(sfrWrEn),
    .sfrWrData(sfrWrData), .serMode(serMode), .wakeIrq(wakeIrq),
    .regRdData(regRdData), .baudDouble(baudDouble), .cpuClkEn(cpuClkEn),
    .periClkEn(periClkEn), .wdtClkEn(wdtClkEn), .modeIdle(modeIdle),
    .modePdown(modePdown)
  );

  // {addr, data, serMode, expected read, expected baudDouble}
  localparam logic [26:0] VEC [7] = '{
    {8'h87, 8'h80, 2'd1, 8'h80, 1'b1},
    {8'h87, 8'h80, 2'd0, 8'h80, 1'b0},
    {8'h86, 8'h0C, 2'd3, 8'h80, 1'b1},
    {8'h87, 8'h0C, 2'd2, 8'h0C, 1'b0},
    {8'h87, 8'h9C, 2'd3, 8'h8C, 1'b1},
    {8'h88, 8'h00, 2'd3, 8'h8C, 1'b1},
    {8'h87, 8'h00, 2'd1, 8'h00, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfrAddr = a; sfrWrData = d; sfrWrEn = 1'b1;
    @(negedge clk);
    sfrWrEn = 1'b0;
  endtask

  function automatic logic [7:0] clks();
    return {3'b0, modeIdle, modePdown, cpuClkEn, periClkEn, wdtClkEn};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 read", regRdData, 8'h00);
    chk("R1 clocks", clks(), 8'h07);

    // R2 R3 table walk
    foreach (VEC[i]) begin
      serMode = VEC[i][10:9];
      wr(VEC[i][26:19], VEC[i][18:11]);
      chk("R2 read", regRdData, VEC[i][8:1]);
      chk("R3 baud", {7'b0, baudDouble}, {7'b0, VEC[i][0]});
    end

    // R5 start without enable
    wr(8'h87, 8'h20);
    @(negedge clk);
    chk("R5 read", regRdData, 8'h00);
    chk("R5 clocks", clks(), 8'h07);

    // R4 R6 enable then stray write then start
    wr(8'h87, 8'h01);
    chk("R4 enable set", regRdData, 8'h01);
    wr(8'h87, 8'h0C);
    chk("R6 enable cleared", regRdData, 8'h0C);
    wr(8'h87, 8'h20);
    @(negedge clk);
    chk("R6 start rejected", regRdData, 8'h00);
    chk("R6 clocks", clks(), 8'h07);

    // R7 idle entry
    wr(8'h87, 8'h01);
    wr(8'h87, 8'h28);
    chk("R7 start visible", regRdData, 8'h28);
    chk("R7 still run", clks(), 8'h07);
    @(negedge clk);
    chk("R7 idle clocks", clks(), 8'h12);
    chk("R7 start cleared", regRdData, 8'h08);

    // R11 writes ignored in idle
    wr(8'h87, 8'h80);
    chk("R11 idle write", regRdData, 8'h08);

    // R8 wake
    wakeIrq = 1'b1;
    @(negedge clk);
    wakeIrq = 1'b0;
    chk("R8 wake clocks", clks(), 8'h07);
    chk("R8 state kept", regRdData, 8'h08);

    // R10 both started, power-down wins
    wr(8'h87, 8'h03);
    wr(8'h87, 8'h60);
    chk("R10 starts visible", regRdData, 8'h60);
    @(negedge clk);
    chk("R10 pdown clocks", clks(), 8'h08);

    // R9 wake ignored, writes ignored, reset exits
    wakeIrq = 1'b1;
    repeat (2) @(negedge clk);
    wakeIrq = 1'b0;
    chk("R9 wake ignored", clks(), 8'h08);
    wr(8'h87, 8'h8C);
    chk("R11 pdown write", regRdData, 8'h00);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 reset exits", clks(), 8'h07);
    chk("R9 reset value", regRdData, 8'h00);

    // R9 power-down alone
    wr(8'h87, 8'h86);
    wr(8'h87, 8'h40);
    @(negedge clk);
    chk("R9 pdown only", clks(), 8'h08);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule